// File: doc/BRIEF.md
# System Control and Status Register Bank

This block is a memory-mapped register bank that gathers the small pieces of system state a SoC needs. The state is a board identifier, a processor identifier, an LED output latch, two configuration words, two sets of flags and a guarded reset-control word. It also holds a free-running reference counter that advances at 24 MHz of elapsed time. A host reaches it over a simple 32-bit request/response bus with a 12-bit byte address, which covers a 4 KB window. Slots reserved for oscillator, switch and similar features return fixed values.

One flag set is volatile and is cleared by the ordinary system reset. The other is kept through that reset and is cleared only by a separate power-on reset. The reset-control word can be written only after software has placed a 16-bit unlock key in the lock register. A write that carries the request bit produces a one-cycle system reset request.

Access sequencing is a four-state machine:
- `ST_IDLE` accepts a request.
- `ST_RD_RSP` presents read data.
- `ST_WR_RSP` acknowledges a write.
- `ST_RST_KICK` acknowledges a write and raises the reset request.

Transitions:
- IDLE→RD_RSP on an accepted read.
- IDLE→WR_RSP on an accepted write.
- IDLE→RST_KICK on a key-qualified reset-control write with bit 8 set.
- Every response state returns to IDLE after one cycle.

Top module: `sysctl_bank`

## Requirements
- R1: After system reset, the LED (0x08), lock (0x20), configuration (0x28, 0x2C), volatile flag (0x30) and reset-control (0x40) registers all read zero, and `led_out` is zero.
- R2: The following locations are read-only constants, and writes to them change nothing:

  | Offset | Value read |
  |--------|------------|
  | 0x00 | `BOARD_ID` |
  | 0x84 | `CPU_ID` |
  | 0x88 | 0xFF000000 |
  | 0x44 | 0x00000001 |
  | 0x50 | 0x00001000 |

- R3: Offset 0x08 is read/write. Its low `LED_W` bits drive `led_out`, and the upper bits read as zero. `led_out` changes only after an accepted write to 0x08, or on reset.
- R4: A write to 0x20 of exactly 0x0000A05F stores 0xA05F. Any other write stores its low 16 bits with bit 15 cleared. The register reads back zero-extended.
- R5: A write to 0x40 takes effect only while the lock register holds 0xA05F. A taking write with bit 8 set raises `sys_reset_req` for exactly the one response cycle of that write. No other write raises it.
- R6: Offset 0x30 reads the volatile flags. A write to 0x30 sets the bits that are one in the data. A write to 0x34 clears the bits that are one in the data. A read of 0x34 returns zero.
- R7: Offsets 0x38 and 0x3C set and clear the non-volatile flags in the same way (0x38 also reads them). These flags survive `rst_n` and are cleared only by `por_n`.
- R8: Offsets 0x28 and 0x2C are plain 32-bit read/write configuration words.
- R9: Offset 0x5C reads a 32-bit counter. It advances TICK_HZ times per CLK_HZ clock cycles, never by more than one per cycle, and wraps silently. With the default parameters, two reads accepted 50 cycles apart differ by exactly 24.
- R10: The reserved slots read zero, ignore writes and do not flag an error. These are 0x04, 0x0C–0x1C, 0x24, 0x48, 0x4C, 0x54, 0x58, 0x60–0x74, 0x80, 0x8C–0x9C and 0xC0–0xD0.
- R11: An access to any other offset, or to a misaligned address, reads zero and changes no register. It raises `bad_access` together with `rsp_valid` for that one response cycle.
- R12: `req_ready` is high only in the idle state. Every accepted request is answered by `rsp_valid` high for exactly the next cycle, and `req_ready` is low during that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| por_n | input | 1 | Synchronous active-low power-on reset (also resets everything) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response cycle |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| bad_access | output | 1 | Response is for an unmapped or misaligned offset |
| led_out | output | LED_W | LED drive |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The hardest state to reach is the reset-request pulse. Software must first write the exact 32-bit key, and then write the reset-control word with bit 8 set. Near misses must not count: a key carrying extra upper bits, or a key with bit 15 missing, must leave the word locked.

The stimulus table therefore walks the lock through failed keys and a locked write before it unlocks. A directed pulse test follows, and the bench counts reset-request pulses at every edge. The persistence of the non-volatile flags is reached by pulsing `rst_n` alone while `por_n` stays high, and only afterwards asserting `por_n`.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 12;
    localparam logic [15:0] UNLOCK_KEY = 16'hA05F;
    localparam int unsigned KICK_BIT = 8;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RD_RSP   = 2'd1,
        ST_WR_RSP   = 2'd2,
        ST_RST_KICK = 2'd3
    } acc_state_e;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_ZERO,
        SEL_ID,
        SEL_LED,
        SEL_LOCK,
        SEL_CFG1,
        SEL_CFG2,
        SEL_FLG_SET,
        SEL_FLG_CLR,
        SEL_NV_SET,
        SEL_NV_CLR,
        SEL_RSTCTL,
        SEL_PCI,
        SEL_LCD,
        SEL_REFCNT,
        SEL_CPUID
    } reg_sel_e;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic              known,
    output logic              cpuid_hi
);

    always_comb begin
        sel      = SEL_NONE;
        known    = 1'b1;
        cpuid_hi = 1'b0;
        if (addr[1:0] != 2'b00) begin
            known = 1'b0;
        end else begin
            case (addr)
                12'h000: sel = SEL_ID;
                12'h008: sel = SEL_LED;
                12'h020: sel = SEL_LOCK;
                12'h028: sel = SEL_CFG1;
                12'h02C: sel = SEL_CFG2;
                12'h030: sel = SEL_FLG_SET;
                12'h034: sel = SEL_FLG_CLR;
                12'h038: sel = SEL_NV_SET;
                12'h03C: sel = SEL_NV_CLR;
                12'h040: sel = SEL_RSTCTL;
                12'h044: sel = SEL_PCI;
                12'h050: sel = SEL_LCD;
                12'h05C: sel = SEL_REFCNT;
                12'h084: sel = SEL_CPUID;
                12'h088: begin
                    sel      = SEL_CPUID;
                    cpuid_hi = 1'b1;
                end
                12'h004, 12'h00C, 12'h010, 12'h014, 12'h018, 12'h01C,
                12'h024, 12'h048, 12'h04C, 12'h054, 12'h058, 12'h060,
                12'h064, 12'h068, 12'h06C, 12'h070, 12'h074, 12'h080,
                12'h08C, 12'h090, 12'h094, 12'h098, 12'h09C, 12'h0C0,
                12'h0C4, 12'h0C8, 12'h0CC, 12'h0D0: sel = SEL_ZERO;
                default: known = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/sysctl_refcnt.sv
module sysctl_refcnt #(
    parameter int unsigned CLK_HZ  = 50_000_000,
    parameter int unsigned TICK_HZ = 24_000_000,
    parameter int unsigned CNT_W   = 32
) (
    input  logic             clk,
    input  logic             srst_n,
    output logic [CNT_W-1:0] count
);

    localparam int unsigned ACC_W = $clog2(CLK_HZ) + 2;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_sum;
    logic             tick;

    assign acc_sum = acc_q + ACC_W'(TICK_HZ);
    assign tick    = (acc_sum >= ACC_W'(CLK_HZ));

    always_ff @(posedge clk) begin
        if (!srst_n) begin
            acc_q <= '0;
            count <= '0;
        end else begin
            acc_q <= tick ? (acc_sum - ACC_W'(CLK_HZ)) : acc_sum;
            if (tick) begin
                count <= count + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sysctl_flagpair.sv
module sysctl_flagpair #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!clr_n) begin
            q <= '0;
        end else if (set_en) begin
            q <= q | wdata;
        end else if (clr_en) begin
            q <= q & ~wdata;
        end
    end

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int unsigned LED_W = 8
) (
    input  logic              clk,
    input  logic              srst_n,
    input  logic              por_n,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [LED_W-1:0]  led_q,
    output logic [15:0]       lock_q,
    output logic [DATA_W-1:0] cfg1_q,
    output logic [DATA_W-1:0] cfg2_q,
    output logic [DATA_W-1:0] flags_q,
    output logic [DATA_W-1:0] nvflags_q,
    output logic [DATA_W-1:0] rstctl_q,
    output logic              key_ok
);

    localparam int unsigned NBANK = 2;

    logic [NBANK-1:0] bank_clr_n;
    logic [NBANK-1:0] bank_set;
    logic [NBANK-1:0] bank_clr;
    logic [DATA_W-1:0] bank_q [NBANK];

    assign key_ok = (lock_q == UNLOCK_KEY);

    // bank 0: volatile flags, bank 1: flags kept across system reset
    assign bank_clr_n[0] = srst_n;
    assign bank_clr_n[1] = por_n;
    assign bank_set[0]   = wr_en && (sel == SEL_FLG_SET);
    assign bank_clr[0]   = wr_en && (sel == SEL_FLG_CLR);
    assign bank_set[1]   = wr_en && (sel == SEL_NV_SET);
    assign bank_clr[1]   = wr_en && (sel == SEL_NV_CLR);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        sysctl_flagpair #(.W(DATA_W)) u_flags (
            .clk    (clk),
            .clr_n  (bank_clr_n[b]),
            .set_en (bank_set[b]),
            .clr_en (bank_clr[b]),
            .wdata  (wdata),
            .q      (bank_q[b])
        );
    end

    assign flags_q   = bank_q[0];
    assign nvflags_q = bank_q[1];

    always_ff @(posedge clk) begin
        if (!srst_n) begin
            led_q    <= '0;
            lock_q   <= '0;
            cfg1_q   <= '0;
            cfg2_q   <= '0;
            rstctl_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_LED:  led_q  <= wdata[LED_W-1:0];
                SEL_LOCK: begin
                    if (wdata == {16'h0000, UNLOCK_KEY}) begin
                        lock_q <= UNLOCK_KEY;
                    end else begin
                        lock_q <= wdata[15:0] & 16'h7FFF;
                    end
                end
                SEL_CFG1: cfg1_q <= wdata;
                SEL_CFG2: cfg2_q <= wdata;
                SEL_RSTCTL: begin
                    if (key_ok) begin
                        rstctl_q <= wdata;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
    import sysctl_pkg::*;
#(
    parameter logic [31:0] BOARD_ID = 32'h0C11_0A05,
    parameter logic [31:0] CPU_ID   = 32'h0C00_0000,
    parameter int unsigned LED_W    = 8,
    parameter int unsigned CLK_HZ   = 50_000_000,
    parameter int unsigned TICK_HZ  = 24_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [11:0]      req_addr,
    input  logic [31:0]      req_wdata,
    output logic             rsp_valid,
    output logic [31:0]      rsp_rdata,
    output logic             bad_access,
    output logic [LED_W-1:0] led_out,
    output logic             sys_reset_req
);

    localparam logic [31:0] CPUID_HI_VAL = 32'hFF00_0000;
    localparam logic [31:0] PCI_VAL      = 32'h0000_0001;
    localparam logic [31:0] LCD_VAL      = 32'h0000_1000;

    acc_state_e state_q, state_d;
    reg_sel_e   sel;
    logic       known, cpuid_hi, accept, wr_en, kick, key_ok, srst_n;
    logic [DATA_W-1:0] rd_mux, rdata_q;
    logic              bad_q;
    logic [LED_W-1:0]  led_q;
    logic [15:0]       lock_q;
    logic [DATA_W-1:0] cfg1_q, cfg2_q, flags_q, nvflags_q, rstctl_q, ref_cnt;

    assign srst_n = rst_n & por_n;
    assign accept = req_valid && (state_q == ST_IDLE);
    assign wr_en  = accept && req_write && known;
    assign kick   = wr_en && (sel == SEL_RSTCTL) && key_ok && req_wdata[KICK_BIT];

    sysctl_decode u_dec (
        .addr     (req_addr),
        .sel      (sel),
        .known    (known),
        .cpuid_hi (cpuid_hi)
    );

    sysctl_regs #(.LED_W(LED_W)) u_regs (
        .clk       (clk),
        .srst_n    (srst_n),
        .por_n     (por_n),
        .wr_en     (wr_en),
        .sel       (sel),
        .wdata     (req_wdata),
        .led_q     (led_q),
        .lock_q    (lock_q),
        .cfg1_q    (cfg1_q),
        .cfg2_q    (cfg2_q),
        .flags_q   (flags_q),
        .nvflags_q (nvflags_q),
        .rstctl_q  (rstctl_q),
        .key_ok    (key_ok)
    );

    sysctl_refcnt #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .CNT_W(DATA_W)) u_refcnt (
        .clk    (clk),
        .srst_n (srst_n),
        .count  (ref_cnt)
    );

    always_comb begin
        unique case (sel)
            SEL_ID:      rd_mux = BOARD_ID;
            SEL_LED:     rd_mux = DATA_W'(led_q);
            SEL_LOCK:    rd_mux = DATA_W'(lock_q);
            SEL_CFG1:    rd_mux = cfg1_q;
            SEL_CFG2:    rd_mux = cfg2_q;
            SEL_FLG_SET: rd_mux = flags_q;
            SEL_NV_SET:  rd_mux = nvflags_q;
            SEL_RSTCTL:  rd_mux = rstctl_q;
            SEL_PCI:     rd_mux = PCI_VAL;
            SEL_LCD:     rd_mux = LCD_VAL;
            SEL_REFCNT:  rd_mux = ref_cnt;
            SEL_CPUID:   rd_mux = cpuid_hi ? CPUID_HI_VAL : CPU_ID;
            default:     rd_mux = '0;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (kick)           state_d = ST_RST_KICK;
                    else if (req_write) state_d = ST_WR_RSP;
                    else                state_d = ST_RD_RSP;
                end
            end
            ST_RD_RSP:   state_d = ST_IDLE;
            ST_WR_RSP:   state_d = ST_IDLE;
            ST_RST_KICK: state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!srst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!srst_n) begin
            rdata_q <= '0;
            bad_q   <= 1'b0;
        end else if (accept) begin
            rdata_q <= (req_write || !known) ? '0 : rd_mux;
            bad_q   <= !known;
        end
    end

    // outputs
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        rsp_valid     = (state_q != ST_IDLE);
        sys_reset_req = (state_q == ST_RST_KICK);
        bad_access    = rsp_valid && bad_q;
        rsp_rdata     = rdata_q;
        led_out       = led_q;
    end

endmodule

// File: rtl/sysctl_bank_chk.sv
module sysctl_bank_chk #(
    parameter int unsigned LED_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             por_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_write,
    input logic [11:0]      req_addr,
    input logic [31:0]      req_wdata,
    input logic             rsp_valid,
    input logic             bad_access,
    input logic             sys_reset_req,
    input logic [LED_W-1:0] led_out,
    input logic [15:0]      lock_val,
    input logic [31:0]      ref_cnt
);

    logic acc_w;
    assign acc_w = req_valid && req_ready && req_write;

    AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (req_valid && req_ready) |=> rsp_valid); // R12
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        rsp_valid |=> !rsp_valid); // R12
    AST_NO_READY_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        rsp_valid |-> !req_ready); // R12
    AST_KICK_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        sys_reset_req |-> rsp_valid); // R5
    AST_KICK_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (acc_w && req_addr == 12'h040 && lock_val != 16'hA05F) |=> !sys_reset_req); // R5
    AST_KICK_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (acc_w && !req_wdata[8]) |=> !sys_reset_req); // R5
    AST_BAD_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        bad_access |-> rsp_valid); // R11
    AST_LOCK_BIT15: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        lock_val[15] |-> (lock_val == 16'hA05F)); // R4
    AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        !(acc_w && req_addr == 12'h008) |=> $stable(led_out)); // R3
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (ref_cnt == $past(ref_cnt)) || (ref_cnt == $past(ref_cnt) + 32'd1)); // R9

endmodule

bind sysctl_bank sysctl_bank_chk #(.LED_W(LED_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .por_n         (por_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_wdata     (req_wdata),
    .rsp_valid     (rsp_valid),
    .bad_access    (bad_access),
    .sys_reset_req (sys_reset_req),
    .led_out       (led_out),
    .lock_val      (lock_q),
    .ref_cnt       (ref_cnt)
);

// File: tb/sysctl_bank_bench.sv
module sysctl_bank_bench;

    localparam logic [31:0] BOARD_ID = 32'h0C11_0A05;
    localparam logic [31:0] CPU_ID   = 32'h0C00_0000;
    localparam int unsigned LED_W    = 8;
    localparam int NV = 39;

    // {write, addr, wdata, expected read, expected bad, requirement}
    localparam logic [81:0] VEC [NV] = '{
        {1'b0, 12'h000, 32'h0,           BOARD_ID,        1'b0, 4'd2},  // R2
        {1'b0, 12'h084, 32'h0,           CPU_ID,          1'b0, 4'd2},  // R2
        {1'b0, 12'h088, 32'h0,           32'hFF00_0000,   1'b0, 4'd2},  // R2
        {1'b0, 12'h044, 32'h0,           32'h0000_0001,   1'b0, 4'd2},  // R2
        {1'b0, 12'h050, 32'h0,           32'h0000_1000,   1'b0, 4'd2},  // R2
        {1'b1, 12'h000, 32'hFFFF_FFFF,   32'h0,           1'b0, 4'd2},  // R2
        {1'b0, 12'h000, 32'h0,           BOARD_ID,        1'b0, 4'd2},  // R2
        {1'b0, 12'h008, 32'h0,           32'h0,           1'b0, 4'd1},  // R1
        {1'b1, 12'h008, 32'h0000_01A5,   32'h0,           1'b0, 4'd3},  // R3
        {1'b0, 12'h008, 32'h0,           32'h0000_00A5,   1'b0, 4'd3},  // R3
        {1'b1, 12'h030, 32'h0000_00F0,   32'h0,           1'b0, 4'd6},  // R6
        {1'b1, 12'h030, 32'h0000_0003,   32'h0,           1'b0, 4'd6},  // R6
        {1'b0, 12'h030, 32'h0,           32'h0000_00F3,   1'b0, 4'd6},  // R6
        {1'b1, 12'h034, 32'h0000_0011,   32'h0,           1'b0, 4'd6},  // R6
        {1'b0, 12'h030, 32'h0,           32'h0000_00E2,   1'b0, 4'd6},  // R6
        {1'b1, 12'h038, 32'h8000_0001,   32'h0,           1'b0, 4'd7},  // R7
        {1'b1, 12'h03C, 32'h0000_0001,   32'h0,           1'b0, 4'd7},  // R7
        {1'b0, 12'h038, 32'h0,           32'h8000_0000,   1'b0, 4'd7},  // R7
        {1'b1, 12'h028, 32'h1234_5678,   32'h0,           1'b0, 4'd8},  // R8
        {1'b1, 12'h02C, 32'h9ABC_DEF0,   32'h0,           1'b0, 4'd8},  // R8
        {1'b0, 12'h028, 32'h0,           32'h1234_5678,   1'b0, 4'd8},  // R8
        {1'b0, 12'h02C, 32'h0,           32'h9ABC_DEF0,   1'b0, 4'd8},  // R8
        {1'b1, 12'h00C, 32'hDEAD_BEEF,   32'h0,           1'b0, 4'd10}, // R10
        {1'b0, 12'h00C, 32'h0,           32'h0,           1'b0, 4'd10}, // R10
        {1'b0, 12'h004, 32'h0,           32'h0,           1'b0, 4'd10}, // R10
        {1'b0, 12'h024, 32'h0,           32'h0,           1'b0, 4'd10}, // R10
        {1'b0, 12'h0A0, 32'h0,           32'h0,           1'b1, 4'd11}, // R11
        {1'b1, 12'h0F0, 32'hFFFF_FFFF,   32'h0,           1'b1, 4'd11}, // R11
        {1'b0, 12'h02A, 32'h0,           32'h0,           1'b1, 4'd11}, // R11 misaligned
        {1'b1, 12'h020, 32'h0000_FFFF,   32'h0,           1'b0, 4'd4},  // R4
        {1'b0, 12'h020, 32'h0,           32'h0000_7FFF,   1'b0, 4'd4},  // R4
        {1'b1, 12'h020, 32'h0001_A05F,   32'h0,           1'b0, 4'd4},  // R4
        {1'b0, 12'h020, 32'h0,           32'h0000_205F,   1'b0, 4'd4},  // R4
        {1'b1, 12'h040, 32'h0000_0155,   32'h0,           1'b0, 4'd5},  // R5 locked
        {1'b0, 12'h040, 32'h0,           32'h0,           1'b0, 4'd5},  // R5
        {1'b1, 12'h020, 32'h0000_A05F,   32'h0,           1'b0, 4'd4},  // R4
        {1'b0, 12'h020, 32'h0,           32'h0000_A05F,   1'b0, 4'd4},  // R4
        {1'b1, 12'h040, 32'h0000_0042,   32'h0,           1'b0, 4'd5},  // R5
        {1'b0, 12'h040, 32'h0,           32'h0000_0042,   1'b0, 4'd5}   // R5
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             por_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic [11:0]      req_addr = '0;
    logic [31:0]      req_wdata = '0;
    logic             req_ready, rsp_valid, bad_access, sys_reset_req;
    logic [31:0]      rsp_rdata;
    logic [LED_W-1:0] led_out;

    int n_tests = 0;
    int n_fail  = 0;
    int kick_cnt = 0;
    logic [31:0] rd;
    logic        bad, kick;
    logic [31:0] c0, c1;

    always #10 clk = ~clk;

    always @(posedge clk) if (sys_reset_req) kick_cnt <= kick_cnt + 1;

    sysctl_bank #(.BOARD_ID(BOARD_ID), .CPU_ID(CPU_ID), .LED_W(LED_W)) u_sysctl_bank (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bad_access(bad_access),
        .led_out(led_out), .sys_reset_req(sys_reset_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // starts and ends at a falling edge with the block idle
    task automatic access(input logic w, input logic [11:0] a, input logic [31:0] d,
                          output logic [31:0] rdata, output logic badf, output logic kk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R12 rsp_valid in response cycle", {31'b0, rsp_valid}, 32'd1);
        chk("R12 req_ready low in response", {31'b0, req_ready}, 32'd0);
        rdata = rsp_rdata; badf = bad_access; kk = sys_reset_req;
        @(negedge clk);
    endtask

    task automatic sys_reset(input logic por);
        rst_n = 1'b0;
        if (por) por_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R12 watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        sys_reset(1'b1);
        chk("R1 led_out after reset", 32'(led_out), 32'h0);
        chk("R12 ready when idle", {31'b0, req_ready}, 32'd1);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i][81], VEC[i][80:69], VEC[i][68:37], rd, bad, kick);
            if (!VEC[i][81]) chk($sformatf("R%0d read data vec %0d", VEC[i][3:0], i), rd, VEC[i][36:5]);
            chk($sformatf("R%0d bad flag vec %0d", VEC[i][3:0], i), {31'b0, bad}, {31'b0, VEC[i][4]});
            if (VEC[i][80:69] == 12'h008 && VEC[i][81])
                chk("R3 led_out follows write", 32'(led_out), 32'h0000_00A5);
        end
        chk("R5 no pulse without bit 8", kick_cnt, 0);

        // R5: unlocked kick
        access(1'b1, 12'h040, 32'h0000_0100, rd, bad, kick);
        chk("R5 pulse in response cycle", {31'b0, kick}, 32'd1);
        chk("R5 exactly one pulse", kick_cnt, 1);
        access(1'b0, 12'h040, 32'h0, rd, bad, kick);
        chk("R5 reset-control updated", rd, 32'h0000_0100);
        access(1'b1, 12'h020, 32'h0, rd, bad, kick);
        access(1'b1, 12'h040, 32'h0000_0100, rd, bad, kick);
        chk("R5 locked kick ignored", kick_cnt, 1);
        access(1'b0, 12'h040, 32'h0, rd, bad, kick);
        chk("R5 locked write ignored", rd, 32'h0000_0100);

        // R9: reads accepted 50 cycles apart
        access(1'b0, 12'h05C, 32'h0, c0, bad, kick);
        repeat (48) @(negedge clk);
        access(1'b0, 12'h05C, 32'h0, c1, bad, kick);
        chk("R9 counter advance over 50 cycles", c1 - c0, 32'd24);

        // R1 / R7: system reset keeps non-volatile flags
        access(1'b1, 12'h030, 32'h0000_0005, rd, bad, kick);
        sys_reset(1'b0);
        chk("R1 led_out cleared", 32'(led_out), 32'h0);
        access(1'b0, 12'h008, 32'h0, rd, bad, kick); chk("R1 led reg", rd, 32'h0);
        access(1'b0, 12'h020, 32'h0, rd, bad, kick); chk("R1 lock reg", rd, 32'h0);
        access(1'b0, 12'h028, 32'h0, rd, bad, kick); chk("R1 cfg1 reg", rd, 32'h0);
        access(1'b0, 12'h02C, 32'h0, rd, bad, kick); chk("R1 cfg2 reg", rd, 32'h0);
        access(1'b0, 12'h030, 32'h0, rd, bad, kick); chk("R1 flags reg", rd, 32'h0);
        access(1'b0, 12'h040, 32'h0, rd, bad, kick); chk("R1 reset-control reg", rd, 32'h0);
        access(1'b0, 12'h038, 32'h0, rd, bad, kick); chk("R7 nv flags survive rst_n", rd, 32'h8000_0000);
        access(1'b0, 12'h034, 32'h0, rd, bad, kick); chk("R6 clear address reads zero", rd, 32'h0);
        sys_reset(1'b1);
        access(1'b0, 12'h038, 32'h0, rd, bad, kick); chk("R7 nv flags cleared by por_n", rd, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule